// File: doc/BRIEF.md
# ESP Encapsulation Framer

This block turns a plaintext payload, arriving as a byte stream marked with start and end flags, into an encapsulating-security-payload frame ready for a downstream cipher stage. Each frame opens with an eight-byte header: the 32-bit security parameters index, then the low 32 bits of a 64-bit per-association sequence counter. The payload follows unchanged. After it come alignment padding, a pad-length byte, the next-header byte, and a 16-byte slot for the integrity check value. That slot is emitted as zero bytes with a marker flag so a later stage can overwrite it with the real tag.

The full 64-bit sequence number of the frame in flight is presented beside the byte stream for the whole frame. The cipher stage uses it both as associated data and as the per-packet IV value. Such an IV only has to be unique, and a counter that never repeats guarantees that. The counter never wraps. Once the next value would be the all-ones maximum, the framer flags the association as exhausted and refuses further packets until reset.

The output is a valid/ready stream with registered outputs. The payload input is stalled by back-pressure. The index and next-header configuration are captured at the start of each frame.

Top module: `esp_framer`

## Requirements
- R1: Each frame starts with 8 header bytes, most significant byte first: the 32-bit `cfg_spi`, then bits 31:0 of the frame's sequence number. `out_sop` is 1 on the first header byte only.
- R2: The payload bytes follow the header unchanged and in order, one output byte per accepted input byte, up to and including the byte flagged `in_eop`.
- R3: After a payload of L bytes, p padding bytes are emitted, where p is the smallest value with (L + p + 2) a multiple of 2^ALIGN_LOG2 (default 4). The padding bytes carry the values 1, 2, ..., p.
- R4: After the padding, a byte equal to p is emitted, then a byte equal to `cfg_next_hdr`.
- R5: The frame ends with ICV_BYTES (default 16) zero bytes, each with `out_icv` = 1, and `out_eop` = 1 on the last of them. `out_icv` and `out_eop` are 0 on every other byte.
- R6: The first frame after reset uses sequence number SEQ_INIT (default 1), and each later frame uses the previous value plus one. `out_seq` carries the full 64-bit value on every byte of the frame.
- R7: When bits 31:0 of the sequence number roll over from all ones to zero, the upper bits advance, while the header still carries only the lower 32 bits.
- R8: Once the next sequence number would be all ones, `sa_exhausted` becomes 1 and stays 1 until reset. From then on a byte offered with `in_sop` = 1 while idle sees `in_ready` = 0, and no new frame starts. The all-ones value is never used.
- R9: While `out_valid` = 1 and `out_ready` = 0, the output byte and its flags hold steady, and no byte is lost or duplicated.
- R10: Bytes offered while idle without `in_sop` are accepted (`in_ready` = 1) and discarded without producing output.
- R11: Reset clears `out_valid` and `sa_exhausted` and returns the sequence counter to SEQ_INIT.
- R12: `cfg_spi` and `cfg_next_hdr` are sampled when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_spi | input | 32 | Security parameters index for the association |
| cfg_next_hdr | input | 8 | Next-header value written into the trailer |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte accepted this cycle |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | First byte of a payload |
| in_eop | input | 1 | Last byte of a payload |
| out_valid | output | 1 | Frame byte available |
| out_ready | input | 1 | Downstream takes the frame byte |
| out_data | output | 8 | Frame byte |
| out_sop | output | 1 | First byte of the frame |
| out_eop | output | 1 | Last byte of the frame |
| out_icv | output | 1 | Byte belongs to the integrity check value slot |
| out_seq | output | SEQ_W | Full sequence number and IV value of the current frame |
| sa_exhausted | output | 1 | Sequence space used up; new packets refused |

## Verification
A corrupted frame-state or index register shows up at the ports within one byte. The next transferred byte is then a header, padding or trailer byte out of place, and it mismatches the byte-exact model frame at once. A wrong length counter stays hidden until the end of the payload, where the pad count and pad-length byte expose it. A faulty sequence counter is caught on the header bytes and on `out_seq` of the very next frame. The low-half rollover and the exhaustion point are driven directly by starting two instances near those values.

// File: rtl/esp_pkg.sv
package esp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_PLEN,
    ST_NXT,
    ST_ICV
  } esp_state_e;

  localparam int HDR_BYTES = 8;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/esp_seq_ctr.sv
module esp_seq_ctr #(
  parameter int          SEQ_W    = 64,
  parameter logic [63:0] SEQ_INIT = 64'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic [SEQ_W-1:0] value,
  output logic             exhausted
);
  logic [SEQ_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= SEQ_INIT[SEQ_W-1:0];
    end else if (take && !exhausted) begin
      cnt_q <= cnt_q + SEQ_W'(1);
    end
  end

  assign value     = cnt_q;
  assign exhausted = &cnt_q;
endmodule

// File: rtl/esp_pad_calc.sv
module esp_pad_calc #(
  parameter int ALIGN_LOG2 = 2
) (
  input  logic [ALIGN_LOG2-1:0] len_mod,
  output logic [7:0]            pad
);
  localparam logic [ALIGN_LOG2-1:0] TRAIL = ALIGN_LOG2'(2);
  logic [ALIGN_LOG2-1:0] fill;

  always_comb begin
    fill = '0 - len_mod - TRAIL;
    pad  = 8'(fill);
  end
endmodule

// File: rtl/esp_out_stage.sv
module esp_out_stage #(
  parameter int SEQ_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [7:0]       d_data,
  input  logic             d_sop,
  input  logic             d_eop,
  input  logic             d_icv,
  input  logic [SEQ_W-1:0] d_seq,
  input  logic             out_ready,
  output logic             adv,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_icv,
  output logic [SEQ_W-1:0] out_seq
);
  assign adv = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_icv   <= 1'b0;
      out_seq   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_data;
      out_sop   <= d_sop;
      out_eop   <= d_eop;
      out_icv   <= d_icv;
      out_seq   <= d_seq;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/esp_framer.sv
module esp_framer
  import esp_pkg::*;
#(
  parameter int          SEQ_W      = 64,
  parameter logic [63:0] SEQ_INIT   = 64'd1,
  parameter int          ALIGN_LOG2 = 2,
  parameter int          ICV_BYTES  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      cfg_spi,
  input  logic [7:0]       cfg_next_hdr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_icv,
  output logic [SEQ_W-1:0] out_seq,
  output logic             sa_exhausted
);
  localparam int IDX_W = 8;
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] ICV_LAST = IDX_W'(ICV_BYTES - 1);

  esp_state_e            state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [7:0]            pad_q;
  logic [ALIGN_LOG2-1:0] len_q;
  logic [31:0]           spi_q;
  logic [7:0]            nh_q;
  logic [SEQ_W-1:0]      seq_q;

  logic             adv, load, start;
  logic [7:0]       d_data;
  logic             d_sop, d_eop, d_icv;
  logic [SEQ_W-1:0] ctr_val;
  logic             ctr_exh;
  logic [ALIGN_LOG2-1:0] len_next;
  logic [7:0]       pad_w;
  logic [63:0]      hdr_w;

  esp_seq_ctr #(.SEQ_W(SEQ_W), .SEQ_INIT(SEQ_INIT)) u_ctr (
    .clk(clk), .rst(rst), .take(start), .value(ctr_val), .exhausted(ctr_exh)
  );

  assign len_next = len_q + ALIGN_LOG2'(1);

  esp_pad_calc #(.ALIGN_LOG2(ALIGN_LOG2)) u_pad (
    .len_mod(len_next), .pad(pad_w)
  );

  esp_out_stage #(.SEQ_W(SEQ_W)) u_out (
    .clk(clk), .rst(rst), .load(load),
    .d_data(d_data), .d_sop(d_sop), .d_eop(d_eop), .d_icv(d_icv), .d_seq(seq_q),
    .out_ready(out_ready), .adv(adv),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_icv(out_icv), .out_seq(out_seq)
  );

  assign sa_exhausted = ctr_exh;
  assign hdr_w        = {spi_q, seq_q[31:0]};
  assign start        = (state_q == ST_IDLE) && in_valid && in_sop && !ctr_exh;

  always_comb begin
    case (state_q)
      ST_IDLE: in_ready = !in_sop;
      ST_PAY:  in_ready = adv;
      default: in_ready = 1'b0;
    endcase
  end

  always_comb begin
    load   = 1'b0;
    d_data = '0;
    d_sop  = 1'b0;
    d_eop  = 1'b0;
    d_icv  = 1'b0;
    case (state_q)
      ST_HDR: begin
        load   = adv;
        d_data = 8'(hdr_w >> {(3'd7 - idx_q[2:0]), 3'b000});
        d_sop  = (idx_q == '0);
      end
      ST_PAY: begin
        load   = adv && in_valid;
        d_data = in_data;
      end
      ST_PAD: begin
        load   = adv;
        d_data = idx_q;
      end
      ST_PLEN: begin
        load   = adv;
        d_data = pad_q;
      end
      ST_NXT: begin
        load   = adv;
        d_data = nh_q;
      end
      ST_ICV: begin
        load  = adv;
        d_icv = 1'b1;
        d_eop = (idx_q == ICV_LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pad_q   <= '0;
      len_q   <= '0;
      spi_q   <= '0;
      nh_q    <= '0;
      seq_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          seq_q   <= ctr_val;
          spi_q   <= cfg_spi;
          nh_q    <= cfg_next_hdr;
          idx_q   <= '0;
          len_q   <= '0;
          state_q <= ST_HDR;
        end
        ST_HDR: if (load) begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == HDR_LAST) state_q <= ST_PAY;
        end
        ST_PAY: if (load) begin
          len_q <= len_next;
          if (in_eop) begin
            pad_q   <= pad_w;
            idx_q   <= IDX_W'(1);
            state_q <= (pad_w == '0) ? ST_PLEN : ST_PAD;
          end
        end
        ST_PAD: if (load) begin
          if (idx_q == pad_q) state_q <= ST_PLEN;
          else                idx_q   <= idx_q + IDX_W'(1);
        end
        ST_PLEN: if (load) state_q <= ST_NXT;
        ST_NXT: if (load) begin
          idx_q   <= '0;
          state_q <= ST_ICV;
        end
        ST_ICV: if (load) begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == ICV_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/esp_framer_chk.sv
module esp_framer_chk #(
  parameter int SEQ_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic             out_icv,
  input logic [SEQ_W-1:0] out_seq,
  input logic             sa_exhausted
);
  logic             seen_q;
  logic [SEQ_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (out_valid && out_ready && out_sop) begin
      seen_q <= 1'b1;
      last_q <= out_seq;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_icv));

  assert_seq_increase_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop && seen_q |-> out_seq > last_q);

  assert_icv_zero_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_icv |-> out_data == 8'h00);

  assert_eop_in_icv_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |-> out_icv);

  assert_exhaust_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    sa_exhausted |=> sa_exhausted);

  assert_no_max_seq_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_seq != {SEQ_W{1'b1}});
endmodule

bind esp_framer esp_framer_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_icv(out_icv),
  .out_seq(out_seq), .sa_exhausted(sa_exhausted)
);

// File: tb/tb_esp_framer.sv
`timescale 1ns/1ps
module tb_esp_framer;
  localparam logic [63:0] MAIN_INIT = 64'h0000_0000_FFFF_FFFE;
  localparam logic [63:0] X_INIT    = 64'hFFFF_FFFF_FFFF_FFFD;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] cfg_spi = '0;
  logic [7:0]  cfg_nh = '0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid, out_sop, out_eop, out_icv, sa_exh;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [63:0] out_seq;

  esp_framer #(.SEQ_INIT(MAIN_INIT)) dut (
    .clk(clk), .rst(rst), .cfg_spi(cfg_spi), .cfg_next_hdr(cfg_nh),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_icv(out_icv),
    .out_seq(out_seq), .sa_exhausted(sa_exh)
  );

  logic        x_in_valid = 1'b0, x_in_sop = 1'b0, x_in_eop = 1'b0;
  logic        x_in_ready, x_out_valid, x_out_sop, x_out_eop, x_out_icv, x_exh;
  logic [7:0]  x_out_data;
  logic [63:0] x_out_seq;

  esp_framer #(.SEQ_INIT(X_INIT)) dut_x (
    .clk(clk), .rst(rst), .cfg_spi(32'h0BAD_F00D), .cfg_next_hdr(8'd17),
    .in_valid(x_in_valid), .in_ready(x_in_ready), .in_data(8'h5A),
    .in_sop(x_in_sop), .in_eop(x_in_eop), .out_valid(x_out_valid), .out_ready(1'b1),
    .out_data(x_out_data), .out_sop(x_out_sop), .out_eop(x_out_eop), .out_icv(x_out_icv),
    .out_seq(x_out_seq), .sa_exhausted(x_exh)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit rnd_ready = 1'b0;
  int lfsr = 32'h1234_5678;
  logic [63:0] model_seq;
  logic [74:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] sop_seqs[$];
  logic [63:0] x_seqs[$];

  task automatic chk(input bit ok, input string tag, input logic [74:0] act, input logic [74:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_b(input logic [7:0] d, input bit s, input bit e, input bit icv,
                        input logic [63:0] sq, input string tag);
    exp_q.push_back({sq, icv, e, s, d});
    tag_q.push_back(tag);
  endtask

  task automatic push_frame(input int len, input logic [31:0] spi, input logic [7:0] nh,
                            input logic [7:0] base, input logic [63:0] sq);
    int p;
    logic [63:0] h;
    h = {spi, sq[31:0]};
    for (int i = 0; i < 8; i++) push_b(h[63-8*i -: 8], i == 0, 0, 0, sq, "R1");
    for (int i = 0; i < len; i++) push_b(8'(base + i), 0, 0, 0, sq, "R2");
    p = (4 - ((len + 2) % 4)) % 4;
    for (int i = 1; i <= p; i++) push_b(8'(i), 0, 0, 0, sq, "R3");
    push_b(8'(p), 0, 0, 0, sq, "R4");
    push_b(nh, 0, 0, 0, sq, "R4");
    for (int i = 0; i < 16; i++) push_b(8'h00, 0, i == 15, 1, sq, "R5");
  endtask

  // Monitor: compare every transfer against the model, then pick next ready.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected byte", {out_seq, out_icv, out_eop, out_sop, out_data}, '0);
      end else begin
        logic [74:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_sop) sop_seqs.push_back(out_seq);
        if (out_seq != e[74:11])
          chk(0, "R6 seq", {out_seq, out_icv, out_eop, out_sop, out_data}, e);
        else
          chk({out_icv, out_eop, out_sop, out_data} == e[10:0], t,
              {out_seq, out_icv, out_eop, out_sop, out_data}, e);
      end
    end
    if (!rst && x_out_valid && x_out_sop) x_seqs.push_back(x_out_seq);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    out_ready = rnd_ready ? lfsr[3] | lfsr[7] : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic put(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    #1;
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  task automatic send(input int len, input logic [31:0] spi, input logic [7:0] nh,
                      input logic [7:0] base, input bit chg);
    cfg_spi = spi;
    cfg_nh  = nh;
    push_frame(len, spi, nh, base, model_seq);
    model_seq = model_seq + 1;
    for (int i = 0; i < len; i++) begin
      put(8'(base + i), i == 0, i == len - 1);
      if (chg && i == 0) begin
        cfg_spi = ~spi;   // R12: must not reach this frame
        cfg_nh  = ~nh;
      end
    end
    @(negedge clk);
    #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 drain", 75'(exp_q.size()), 0);
  endtask

  task automatic xput(input bit s, input bit e);
    @(negedge clk);
    #1;
    x_in_valid = 1'b1; x_in_sop = s; x_in_eop = e;
    #1;
    while (!x_in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    x_in_valid = 1'b0; x_in_sop = 1'b0; x_in_eop = 1'b0;
  endtask

  initial begin
    model_seq = MAIN_INIT;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R11: reset state
    chk(out_valid == 0, "R11 out_valid", 75'(out_valid), 0);
    chk(sa_exh == 0, "R11 sa_exhausted", 75'(sa_exh), 0);
    chk(x_exh == 0, "R11 sa_exhausted x", 75'(x_exh), 0);

    // R10: stray bytes while idle are discarded
    put(8'hAA, 0, 0);
    put(8'hBB, 0, 1);
    put(8'hCC, 0, 0);
    @(negedge clk); #1; in_valid = 1'b0;
    repeat (10) @(negedge clk);
    #2;
    chk(out_valid == 0, "R10 stray bytes", 75'(out_valid), 0);

    // R1-style header, R3 pad lengths for payloads 1..8, R7 rollover
    for (int l = 1; l <= 8; l++) send(l, 32'hC0DE_0000 + l, 8'd50, 8'(16 * l), 0);
    drain();
    chk(sop_seqs.size() >= 3 && sop_seqs[2] == 64'h0000_0001_0000_0000, "R7 rollover",
        75'(sop_seqs.size() >= 3 ? sop_seqs[2] : 64'h0), 75'(64'h0000_0001_0000_0000));
    chk(sop_seqs.size() >= 2 && sop_seqs[1] == 64'h0000_0000_FFFF_FFFF, "R6 second seq",
        75'(sop_seqs.size() >= 2 ? sop_seqs[1] : 64'h0), 75'(64'h0000_0000_FFFF_FFFF));

    // R9: random back-pressure
    rnd_ready = 1'b1;
    send(5, 32'h1111_2222, 8'd4, 8'h10, 0);
    send(9, 32'h3333_4444, 8'd41, 8'h80, 0);
    send(13, 32'h5555_6666, 8'd6, 8'hF0, 0);
    send(20, 32'h7777_8888, 8'd59, 8'h33, 0);
    // R12: config changes mid-frame
    send(6, 32'hDEAD_BEEF, 8'd50, 8'h01, 1);
    drain();
    rnd_ready = 1'b0;
    send(3, 32'hFACE_0001, 8'd17, 8'h44, 1);
    drain();

    // R11: reset mid-run restores SEQ_INIT
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    exp_q.delete(); tag_q.delete(); sop_seqs.delete(); x_seqs.delete();
    model_seq = MAIN_INIT;
    send(3, 32'h0102_0304, 8'd1, 8'h20, 0);
    drain();
    chk(sop_seqs.size() == 1 && sop_seqs[0] == MAIN_INIT, "R11 seq after reset",
        75'(sop_seqs.size() == 1 ? sop_seqs[0] : 64'h0), 75'(MAIN_INIT));

    // R8: exhaustion on second instance
    xput(1, 1);
    repeat (60) @(negedge clk);
    xput(1, 1);
    repeat (60) @(negedge clk);
    #2;
    chk(x_exh == 1, "R8 exhausted flag", 75'(x_exh), 1);
    chk(x_seqs.size() == 2, "R8 frame count", 75'(x_seqs.size()), 2);
    if (x_seqs.size() == 2) begin
      chk(x_seqs[0] == X_INIT, "R8 first seq", 75'(x_seqs[0]), 75'(X_INIT));
      chk(x_seqs[1] == X_INIT + 1, "R8 last seq", 75'(x_seqs[1]), 75'(X_INIT + 1));
    end
    @(negedge clk); #1;
    x_in_valid = 1'b1; x_in_sop = 1'b1; x_in_eop = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2;
      chk(x_in_ready == 0, "R8 in_ready refused", 75'(x_in_ready), 0);
      chk(x_out_valid == 0, "R8 no new frame", 75'(x_out_valid), 0);
    end
    x_in_valid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule